// File: doc/BRIEF.md
# Serial 1-0-1 Sequence Flagger

This block watches a serial bit stream that advances by one bit on every clock and raises a one-cycle flag whenever the three most recent bits form the sequence 1, 0, 1. Matches may share bits. The final 1 of one match can serve as the leading 1 of the next, so the stream 10101 raises the flag twice. The machine has four states. Each state counts how many leading digits of the sequence are matched by the tail of the stream. The 2-bit state code is brought out so that the state can be observed.

A small stimulus source sits beside the detector. An address counter runs freely, advances one location per clock and wraps after the last location. It indexes a constant bit store whose contents are set by a parameter. A select input chooses whether the detector sees the stored bit or an external serial input. The bit actually consumed in each cycle is brought out as well. This lets a stored example stream run unattended, and it also lets arbitrary streams be driven from outside.

Top module: `pat101_detector`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) leaves the state code at 00 and the stream address at 0 after that edge.
- R2: The state code `state_q` is 00 for no digits matched, 01 for a trailing 1, 10 for a trailing 1-0, and 11 right after a full match. Bit 0 of `state_q` is the low code bit.
- R3: Transitions on each rising edge: 00 goes to 01 on a 1 and stays on a 0. 01 stays on a 1 and goes to 10 on a 0. 10 goes to 11 on a 1 and to 00 on a 0. 11 goes to 01 on a 1 and to 10 on a 0.
- R4: `match_flag` is high in the same cycle as the completing bit, exactly when the state is 10 and the consumed bit is 1. It is low otherwise.
- R5: The state is 11 in the cycle after `match_flag` was high, and in no other cycle.
- R6: Overlapping matches are all flagged. An alternating 1,0,1,0,... stream flags every second bit from the third bit onward.
- R7: A run of 1s never raises `match_flag` and holds the state at 01.
- R8: `rom_addr` increases by one per clock and returns to 0 after location ROM_LEN-1.
- R9: With `use_ext` low, the consumed bit is bit `rom_addr` of the STREAM parameter. The default STREAM, read from address 0 upward, is 0010101011101, and the flags for it are 0000101010001.
- R10: With `use_ext` high, the consumed bit is `ext_bit`, and the stored stream has no effect on the detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| use_ext | input | 1 | 1 selects `ext_bit` as the serial source, 0 selects the stored stream |
| ext_bit | input | 1 | External serial data bit |
| match_flag | output | 1 | High for the cycle whose bit completes a 1-0-1 match |
| state_q | output | 2 | Present state code |
| cur_bit | output | 1 | The bit consumed in this cycle |
| rom_addr | output | ADDR_W | Present stored-stream address |

## Verification
`match_flag` and `cur_bit` are combinational from the present state and source, so they are due in the same cycle the bit is applied. The bench sets the inputs on the falling edge and samples a short delay later, before the next rising edge. `state_q` and `rom_addr` respond one register later. The bench therefore compares them with a model built from the bits pushed into its history at earlier rising edges, so each comparison sees exactly the effect of the bits already clocked in. After reset the address and state are checked one edge after `rst` was sampled high.

// File: rtl/pat101_pkg.sv
package pat101_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ONE  = 2'b01,
    ST_ONEZ = 2'b10,
    ST_HIT  = 2'b11
  } det_state_t;

  function automatic det_state_t step_state(input det_state_t cur, input logic b);
    det_state_t nxt;
    case (cur)
      ST_IDLE: nxt = b ? ST_ONE  : ST_IDLE;
      ST_ONE:  nxt = b ? ST_ONE  : ST_ONEZ;
      ST_ONEZ: nxt = b ? ST_HIT  : ST_IDLE;
      default: nxt = b ? ST_ONE  : ST_ONEZ;
    endcase
    return nxt;
  endfunction

  function automatic logic flag_of(input det_state_t cur, input logic b);
    return (cur == ST_ONEZ) && b;
  endfunction

endpackage

// File: rtl/pat101_stim.sv
module pat101_stim #(
  parameter int ROM_LEN = 13,
  parameter logic [ROM_LEN-1:0] STREAM = 13'b1011101010100,
  localparam int ADDR_W = (ROM_LEN > 1) ? $clog2(ROM_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] addr,
  output logic              bit_out
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(ROM_LEN - 1);

  logic wrap_now;
  assign wrap_now = (addr == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (rst)           addr <= '0;
    else if (wrap_now) addr <= '0;
    else               addr <= addr + 1'b1;
  end

  always_comb begin
    bit_out = 1'b0;
    for (int i = 0; i < ROM_LEN; i++)
      if (addr == ADDR_W'(i)) bit_out = STREAM[i];
  end
endmodule

// File: rtl/pat101_next.sv
module pat101_next
  import pat101_pkg::*;
(
  input  det_state_t cur,
  input  logic       din,
  output det_state_t nxt,
  output logic       enter_hit
);
  always_comb begin
    nxt       = step_state(cur, din);
    enter_hit = (nxt == ST_HIT);
  end
endmodule

// File: rtl/pat101_flag.sv
module pat101_flag
  import pat101_pkg::*;
(
  input  det_state_t cur,
  input  logic       din,
  output logic       flag
);
  always_comb flag = flag_of(cur, din);
endmodule

// File: rtl/pat101_detector.sv
module pat101_detector
  import pat101_pkg::*;
#(
  parameter int ROM_LEN = 13,
  parameter logic [ROM_LEN-1:0] STREAM = 13'b1011101010100,
  localparam int ADDR_W = (ROM_LEN > 1) ? $clog2(ROM_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              use_ext,
  input  logic              ext_bit,
  output logic              match_flag,
  output logic [1:0]        state_q,
  output logic              cur_bit,
  output logic [ADDR_W-1:0] rom_addr
);
  det_state_t st_r, st_n;
  logic       rom_bit;
  logic       enter_hit;

  pat101_stim #(.ROM_LEN(ROM_LEN), .STREAM(STREAM)) u_stim (
    .clk(clk), .rst(rst), .addr(rom_addr), .bit_out(rom_bit)
  );

  assign cur_bit = use_ext ? ext_bit : rom_bit;

  pat101_next u_next (.cur(st_r), .din(cur_bit), .nxt(st_n), .enter_hit(enter_hit));
  pat101_flag u_flag (.cur(st_r), .din(cur_bit), .flag(match_flag));

  always_ff @(posedge clk) begin
    if (rst) st_r <= ST_IDLE;
    else     st_r <= st_n;
  end

  assign state_q = st_r;
endmodule

// File: rtl/pat101_checker.sv
module pat101_checker #(
  parameter int ROM_LEN = 13,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              match_flag,
  input logic              enter_hit,
  input logic [1:0]        state_q,
  input logic              cur_bit,
  input logic [ADDR_W-1:0] rom_addr
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(ROM_LEN - 1);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (state_q == 2'b00 && rom_addr == '0));

  a_r4_flag_cond: assert property (@(posedge clk) disable iff (rst)
    match_flag |-> (state_q == 2'b10 && cur_bit));

  a_r4_flag_is_hit_entry: assert property (@(posedge clk) disable iff (rst)
    match_flag == enter_hit);

  a_r5_flag_then_hit: assert property (@(posedge clk) disable iff (rst)
    match_flag |=> state_q == 2'b11);

  a_r5_hit_only_after_flag: assert property (@(posedge clk) disable iff (rst)
    (!match_flag) |=> state_q != 2'b11);

  a_r7_ones_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == 2'b01 && cur_bit) |=> state_q == 2'b01);

  a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (state_q == 2'b00 && !cur_bit) |=> state_q == 2'b00);

  a_r8_addr_step: assert property (@(posedge clk) disable iff (rst)
    (rom_addr != LAST_ADDR) |=> rom_addr == $past(rom_addr) + 1'b1);

  a_r8_addr_wrap: assert property (@(posedge clk) disable iff (rst)
    (rom_addr == LAST_ADDR) |=> rom_addr == '0);
endmodule

bind pat101_detector pat101_checker #(.ROM_LEN(ROM_LEN), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .match_flag(match_flag), .enter_hit(enter_hit),
  .state_q(state_q), .cur_bit(cur_bit), .rom_addr(rom_addr)
);

// File: tb/sim_pat101_detector.sv
module sim_pat101_detector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic use_ext = 1'b0;
  logic ext_bit = 1'b0;
  logic match_flag, cur_bit;
  logic [1:0] state_q;
  logic [3:0] rom_addr;

  int vectors = 0;
  int misses = 0;
  int addr_exp = 0;
  int cycles = 0;
  bit hist[$];
  string stream_s = "0010101011101";
  string flags_s  = "0000101010001";

  always #5 clk = ~clk;

  pat101_detector u0 (
    .clk(clk), .rst(rst), .use_ext(use_ext), .ext_bit(ext_bit),
    .match_flag(match_flag), .state_q(state_q), .cur_bit(cur_bit), .rom_addr(rom_addr)
  );

  function automatic int model_state();
    int n = hist.size();
    if (n >= 3 && hist[n-3] && !hist[n-2] && hist[n-1]) return 3;
    if (n >= 2 && hist[n-2] && !hist[n-1]) return 2;
    if (n >= 1 && hist[n-1]) return 1;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  // one serial bit: drive at falling edge, compare before the next rising edge
  task automatic step(input bit ext, input bit sel, input string tag);
    bit b;
    int ms;
    bit zexp;
    @(negedge clk);
    rst = 1'b0;
    use_ext = sel;
    ext_bit = ext;
    #2;
    b = sel ? ext : (stream_s[addr_exp] == "1");
    ms = model_state();
    zexp = (ms == 2) && b;
    check(sel ? "R10 source" : "R9 rom bit", cur_bit, b);
    check("R3 state", state_q, ms);
    check({"R4 flag ", tag}, match_flag, zexp);
    check("R8 address", rom_addr, addr_exp);
    @(posedge clk);
    hist.push_back(b);
    addr_exp = (addr_exp + 1) % 13;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check("R1 reset state", state_q, 0);
    check("R1 reset addr", rom_addr, 0);
    hist.delete();
    addr_exp = 0;
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        misses++;
        $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    int lfsr;
    do_reset();
    // R9: stored example stream, with the explicit expected flag string
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      rst = 1'b0;
      use_ext = 1'b0;
      #2;
      check("R9 example flags", match_flag, flags_s[i] == "1");
      @(posedge clk);
      hist.push_back(stream_s[i] == "1");
      addr_exp = (addr_exp + 1) % 13;
    end
    // R8 wrap and R2/R5: after the last bit the state shows 11
    @(negedge clk);
    #2;
    check("R5 hit after flag", state_q, 3);
    check("R8 wrap to zero", rom_addr, 0);
    @(posedge clk);
    hist.push_back(1'b0);
    addr_exp = 1;
    for (int i = 0; i < 25; i++) step(1'b0, 1'b0, "rom");

    // R7: a run of ones
    do_reset();
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 1'b1, "R7 ones");
      if (i > 0) check("R7 state held", state_q, 1);
      check("R7 no flag", match_flag, 0);
    end

    // R6: alternating 1,0 stream, overlap
    do_reset();
    for (int i = 0; i < 20; i++) begin
      step(((i % 2) == 0), 1'b1, "R6 alt");
      check("R6 overlap flag", match_flag, (i >= 2) && ((i % 2) == 0));
    end

    // R10: external zeros while stored stream would carry ones
    do_reset();
    for (int i = 0; i < 13; i++) begin
      step(1'b0, 1'b1, "R10 zeros");
      check("R10 stream ignored", state_q, 0);
    end

    // pseudo-random mix, reset in the middle
    do_reset();
    lfsr = 32'h1ace;
    for (int i = 0; i < 300; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
      step(lfsr[0], lfsr[3], "R3 mix");
      if (i == 150) do_reset();
    end
    finish_run();
  end
endmodule